// File: doc/BRIEF.md
# Trigger-Level Sample FIFO with Block-Ready Pulse

This block buffers converted samples between a multi-channel converter core and a host processor that reads over a parallel port. The converter side writes one word per accepted `wr_en` on the conversion clock. The block counts accepted words in blocks whose size is a programmed trigger level. Each time a full block has arrived, it drops `dav_n` low for one clock. The host answers each pulse by reading exactly that many words.

Host reads are framed by a composite strobe built from two chip selects and a read line. The host drives that strobe with no relation to the conversion clock. The block brings the strobe into the clock domain through a synchroniser and removes one word when the strobe is released. Which trigger levels are legal depends on how many input channels are enabled. An illegal request falls back to the smallest legal level. A write into a full buffer is dropped and sets a sticky overflow flag.

Top module: `smp_blk_fifo`

## Requirements
- R1: The read strobe is active only while `cs0_n`=0, `cs1`=1 and `rd_n`=0. Any other combination removes no word.
- R2: Releasing an active strobe removes exactly one word. The decrease in `fill` is visible no later than the fourth rising clock edge after the release.
- R3: Words come out on `rd_data` in the order they were accepted. `rd_data` shows the oldest unread word while the strobe is held.
- R4: `dav_n` goes low for one clock cycle after the edge that accepts the write completing a block of trigger-level words. It goes low at no other time.
- R5: `chan_sel` encodes the channel count as 0,1,2,3 for 1,2,3,4 channels. The legal levels are {1,4,8,14} for one channel, {2,4,8,12} for two, {3,6,9,12} for three and {4,8,12} for four. A legal `lvl_req` is used as given.
- R6: An illegal `lvl_req` is replaced by the smallest legal level for the selected channel count, which equals that channel count.
- R7: With 16 words held, a write is dropped and `ovf` is set. `ovf` stays set until reset, and the 16 held words stay intact and in order.
- R8: A strobe released while the buffer is empty changes nothing. `rd_data` keeps showing the last word read, and the next accepted word is the next one read.
- R9: A synchronous reset (`rst`=1) clears `fill`, the block counter and `ovf`, and returns `dav_n` high.
- R10: `fill` reports the number of unread words. It changes by at most one per clock and never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write one converted word |
| wr_data | input | 10 | Converted word |
| chan_sel | input | 2 | Enabled channel count minus one |
| lvl_req | input | 4 | Requested trigger level in words |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| rd_n | input | 1 | Host read line, active low |
| rd_data | output | 10 | Oldest unread word, or the last word read when empty |
| dav_n | output | 1 | Block-ready pulse, active low |
| ovf | output | 1 | Sticky overflow flag |
| fill | output | 5 | Number of unread words |

## Verification
The bound checker watches several properties on every clock. It checks that a `dav_n` pulse only ever follows an accepted write, that `ovf` only rises on a write into a full buffer and then stays set, that `fill` steps by at most one and stays within depth, that an empty, idle buffer stays empty, and that reset returns the outputs to their idle values. Other behaviour needs whole sequences and is shown only by the bench scenarios. These are the pulse spacing for every channel-count and level pair, the fallback on illegal levels, the word order through the asynchronous strobe path, the decoding of the chip-select combinations, and the content kept after an overflow or an empty read.

// File: rtl/smp_blk_pkg.sv
package smp_blk_pkg;
   localparam int LVL_W   = 4;
   localparam int MAX_LVL = 14;

   typedef logic [LVL_W-1:0] lvl_t;

   typedef enum logic [1:0] {
      CH1 = 2'd0,
      CH2 = 2'd1,
      CH3 = 2'd2,
      CH4 = 2'd3
   } chan_e;
endpackage

// File: rtl/smp_strobe_sync.sv
// Decodes the host strobe, brings it into the clock domain and flags its release.
module smp_strobe_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic cs0_n,
   input  logic cs1,
   input  logic rd_n,
   output logic release_p
);
   logic              strobe_raw;
   logic [STAGES-1:0] chain;
   logic              hold_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("smp_strobe_sync: STAGES must be at least 2");
   end

   assign strobe_raw = ~cs0_n & cs1 & ~rd_n;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain  <= '0;
         hold_q <= 1'b0;
      end else begin
         chain  <= {chain[STAGES-2:0], strobe_raw};
         hold_q <= chain[STAGES-1];
      end
   end

   // one-cycle flag on the falling edge of the synchronised strobe
   assign release_p = hold_q & ~chain[STAGES-1];
endmodule

// File: rtl/smp_level_sel.sv
// Maps a requested trigger level to the level in force for a channel count.
module smp_level_sel
   import smp_blk_pkg::*;
(
   input  logic [1:0] chan,
   input  lvl_t       req,
   output lvl_t       lvl
);
   chan_e ch;
   logic  legal;

   assign ch = chan_e'(chan);

   always_comb begin
      unique case (ch)
         CH1:     legal = (req == 4'd1) || (req == 4'd4) || (req == 4'd8) || (req == 4'd14);
         CH2:     legal = (req == 4'd2) || (req == 4'd4) || (req == 4'd8) || (req == 4'd12);
         CH3:     legal = (req == 4'd3) || (req == 4'd6) || (req == 4'd9) || (req == 4'd12);
         default: legal = (req == 4'd4) || (req == 4'd8) || (req == 4'd12);
      endcase
      // smallest legal level equals the channel count
      lvl = legal ? req : lvl_t'(chan) + lvl_t'(1);
   end
endmodule

// File: rtl/smp_store.sv
// Sample storage: one synchronous write port, one asynchronous read port.
module smp_store #(
   parameter int W     = 10,
   parameter int DEPTH = 16,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/smp_blk_fifo.sv
// Trigger-level sample buffer with a block-ready pulse toward an asynchronous host.
module smp_blk_fifo
   import smp_blk_pkg::*;
#(
   parameter int W           = 10,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic [W-1:0]               wr_data,
   input  logic [1:0]                 chan_sel,
   input  logic [LVL_W-1:0]           lvl_req,
   input  logic                       cs0_n,
   input  logic                       cs1,
   input  logic                       rd_n,
   output logic [W-1:0]               rd_data,
   output logic                       dav_n,
   output logic                       ovf,
   output logic [$clog2(DEPTH+1)-1:0] fill
);
   localparam int AW   = $clog2(DEPTH);
   localparam int CW   = $clog2(DEPTH + 1);
   localparam bit POW2 = ((2 ** AW) == DEPTH);

   if (DEPTH < MAX_LVL) begin : g_bad_depth
      $error("smp_blk_fifo: DEPTH must hold the largest trigger level");
   end
   if (W < 1) begin : g_bad_width
      $error("smp_blk_fifo: W must be positive");
   end

   logic [AW-1:0] wptr, rptr, wptr_nx, rptr_nx, rptr_pv, raddr;
   logic [CW-1:0] cnt;
   lvl_t          lvl, acc, acc_inc;
   logic          dav_q, ovf_q, rel_p, wr_ok, pop_ok;

   smp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst       (rst),
      .cs0_n     (cs0_n),
      .cs1       (cs1),
      .rd_n      (rd_n),
      .release_p (rel_p)
   );

   smp_level_sel u_lvl (
      .chan (chan_sel),
      .req  (lvl_req),
      .lvl  (lvl)
   );

   // pointer stepping: natural wrap for a power of two, explicit wrap otherwise
   if (POW2) begin : g_wrap_pow2
      assign wptr_nx = wptr + 1'b1;
      assign rptr_nx = rptr + 1'b1;
      assign rptr_pv = rptr - 1'b1;
   end else begin : g_wrap_cmp
      assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      assign rptr_pv = (rptr == '0) ? AW'(DEPTH - 1) : rptr - 1'b1;
   end

   assign wr_ok   = wr_en && (cnt != CW'(DEPTH));
   assign pop_ok  = rel_p && (cnt != '0);
   assign raddr   = (cnt == '0) ? rptr_pv : rptr;
   assign acc_inc = acc + lvl_t'(1);

   smp_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk   (clk),
      .we    (wr_ok),
      .waddr (wptr),
      .wdata (wr_data),
      .raddr (raddr),
      .rdata (rd_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr  <= '0;
         rptr  <= '0;
         cnt   <= '0;
         acc   <= '0;
         dav_q <= 1'b1;
         ovf_q <= 1'b0;
      end else begin
         if (wr_ok)  wptr <= wptr_nx;
         if (pop_ok) rptr <= rptr_nx;
         unique case ({wr_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
         if (wr_en && !wr_ok) ovf_q <= 1'b1;
         dav_q <= 1'b1;
         if (wr_ok) begin
            if (acc_inc >= lvl) begin
               acc   <= '0;
               dav_q <= 1'b0;
            end else begin
               acc <= acc_inc;
            end
         end
      end
   end

   assign dav_n = dav_q;
   assign ovf   = ovf_q;
   assign fill  = cnt;
endmodule

// File: rtl/smp_blk_fifo_chk.sv
module smp_blk_fifo_chk #(
   parameter int DEPTH = 16,
   parameter int CW    = 5
) (
   input logic          clk,
   input logic          rst,
   input logic          wr_en,
   input logic          dav_n,
   input logic          ovf,
   input logic [CW-1:0] fill
);
   // R4
   dav_after_write_chk: assert property (@(posedge clk) disable iff (rst)
      !dav_n |-> ($past(wr_en) && (int'($past(fill)) != DEPTH)));

   // R7
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      ovf |=> ovf);

   // R7
   ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ovf) |-> ($past(wr_en) && (int'($past(fill)) == DEPTH)));

   // R10
   fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
      int'(fill) <= DEPTH);

   // R10
   fill_step_chk: assert property (@(posedge clk) disable iff (rst)
      (int'(fill) == int'($past(fill))) || (int'(fill) == int'($past(fill)) + 1)
      || (int'(fill) + 1 == int'($past(fill))));

   // R8
   empty_idle_chk: assert property (@(posedge clk) disable iff (rst)
      ((fill == '0) && !wr_en) |=> (fill == '0));

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> ((fill == '0) && dav_n && !ovf));
endmodule

bind smp_blk_fifo smp_blk_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .wr_en (wr_en),
   .dav_n (dav_n),
   .ovf   (ovf),
   .fill  (fill)
);

// File: tb/sim_smp_blk_fifo.sv
module sim_smp_blk_fifo;
   localparam int W     = 10;
   localparam int DEPTH = 16;
   localparam int CW    = 5;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic [W-1:0]  wr_data = '0;
   logic [1:0]    chan_sel = 2'd0;
   logic [3:0]    lvl_req = 4'd1;
   logic          cs0_n = 1'b1;
   logic          cs1 = 1'b0;
   logic          rd_n = 1'b1;
   logic [W-1:0]  rd_data;
   logic          dav_n;
   logic          ovf;
   logic [CW-1:0] fill;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   smp_blk_fifo #(.W(W), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .chan_sel(chan_sel), .lvl_req(lvl_req),
      .cs0_n(cs0_n), .cs1(cs1), .rd_n(rd_n),
      .rd_data(rd_data), .dav_n(dav_n), .ovf(ovf), .fill(fill)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_lvl(input int ch, input int t);
      bit ok;
      case (ch)
         1:       ok = (t == 1) || (t == 4) || (t == 8) || (t == 14);
         2:       ok = (t == 2) || (t == 4) || (t == 8) || (t == 12);
         3:       ok = (t >= 3) && (t <= 12) && (t % 3 == 0);
         default: ok = (t >= 4) && (t <= 12) && (t % 4 == 0);
      endcase
      return ok ? t : ch;
   endfunction

   function automatic int pat(input int a, input int b, input int i);
      return (a * 151 + b * 29 + i * 37) % 1024;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; wr_en = 1'b0; cs0_n = 1'b1; cs1 = 1'b0; rd_n = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic push(input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic strobe(input logic c0n, input logic c1v, input logic rdn, output int seen);
      @(negedge clk);
      cs0_n = c0n; cs1 = c1v; rd_n = rdn;
      repeat (2) @(negedge clk);
      seen = int'(rd_data);
      cs0_n = 1'b1; cs1 = 1'b0; rd_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int v;
      do_reset();
      // R9 reset state
      chk("R9", "fill after reset", int'(fill), 0);
      chk("R9", "dav_n after reset", int'(dav_n), 1);
      chk("R9", "ovf after reset", int'(ovf), 0);

      // R4 R5 R6 R3 R2 sweep over every channel count and requested level
      for (int ch = 0; ch < 4; ch++) begin
         for (int t = 0; t < 16; t++) begin
            int e;
            string tag;
            do_reset();
            chan_sel = 2'(ch);
            lvl_req  = 4'(t);
            e   = exp_lvl(ch + 1, t);
            tag = (e == t) ? "R5" : "R6";
            for (int i = 1; i <= 14; i++) begin
               push(pat(ch, t, i));
               chk(tag, "dav_n after write", int'(dav_n), (i % e == 0) ? 0 : 1);
               if (i % e == 0) begin
                  @(negedge clk);
                  chk("R4", "dav_n one cycle later", int'(dav_n), 1);
               end
            end
            chk("R10", "fill after 14 writes", int'(fill), 14);
            for (int i = 1; i <= 14; i++) begin
               strobe(1'b0, 1'b1, 1'b0, v);
               chk("R3", "read order", v, pat(ch, t, i));
            end
            chk("R2", "fill after draining", int'(fill), 0);
         end
      end

      // R1 strobe decoding
      do_reset();
      for (int i = 0; i < 3; i++) push(pat(7, 1, i));
      strobe(1'b1, 1'b1, 1'b0, v); chk("R1", "cs0_n high", int'(fill), 3);
      strobe(1'b0, 1'b0, 1'b0, v); chk("R1", "cs1 low", int'(fill), 3);
      strobe(1'b0, 1'b1, 1'b1, v); chk("R1", "rd_n high", int'(fill), 3);
      strobe(1'b1, 1'b0, 1'b1, v); chk("R1", "all idle", int'(fill), 3);
      strobe(1'b0, 1'b1, 1'b0, v);
      chk("R1", "decoded read data", v, pat(7, 1, 0));
      chk("R2", "one word removed", int'(fill), 2);

      // R8 empty reads
      do_reset();
      push(321);
      strobe(1'b0, 1'b1, 1'b0, v);
      chk("R8", "first read", v, 321);
      chk("R8", "rd_data when empty", int'(rd_data), 321);
      strobe(1'b0, 1'b1, 1'b0, v);
      chk("R8", "empty read data", v, 321);
      chk("R8", "fill after empty read", int'(fill), 0);
      push(654);
      strobe(1'b0, 1'b1, 1'b0, v);
      chk("R8", "next word after empty read", v, 654);
      chk("R8", "fill drained", int'(fill), 0);

      // R7 overflow
      do_reset();
      chan_sel = 2'd0; lvl_req = 4'd1;
      for (int i = 0; i < 17; i++) push(pat(3, 9, i));
      chk("R7", "fill when full", int'(fill), 16);
      chk("R7", "ovf set", int'(ovf), 1);
      for (int i = 0; i < 16; i++) begin
         strobe(1'b0, 1'b1, 1'b0, v);
         chk("R7", "kept word", v, pat(3, 9, i));
      end
      chk("R7", "fill after drain", int'(fill), 0);
      chk("R7", "ovf sticky", int'(ovf), 1);
      chk("R7", "dropped word absent", int'(rd_data), pat(3, 9, 15));
      do_reset();
      chk("R9", "ovf cleared", int'(ovf), 0);

      // R9 partial block discarded by reset
      chan_sel = 2'd0; lvl_req = 4'd4;
      for (int i = 0; i < 3; i++) push(i);
      do_reset();
      chk("R9", "fill cleared", int'(fill), 0);
      push(5);
      chk("R9", "no pulse from old partial block", int'(dav_n), 1);
      for (int i = 0; i < 3; i++) push(6 + i);
      chk("R9", "pulse after fresh block", int'(dav_n), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule